// File: doc/BRIEF.md
# Pulsed Receiver Mode Sequencer

This block is the mode controller of a non-coherent pulsed-radio receiver baseband. It decides what the receiver is doing at every clock. It sleeps until woken. It then averages samples for one code period and checks for the presence of a signal. On a hit it runs the full phase search. It then hunts for the start-of-frame pattern and finally counts payload bits before going back to sleep.

In each mode it enables the clocks of only those correlation tiles that the mode needs. The radio front end is powered only while the receiver consumes samples. When the phase search reports its winner, the block passes the phase index to the front-end delay line. It also loads the winning sample offset into a skip counter, which holds off the frame search until the code boundary is aligned.

The search results, the frame outcome, the timeout and the payload length come from neighbouring logic. This block sequences them and does no correlation arithmetic itself.

Top module: `rxseq_ctrl`

## Requirements
- R1: After reset the state is sleep, all tile clock enables are low, the RF enable is low, and the phase and skip outputs are zero.
- R2: In sleep, `wake` moves the state to averaging on the next edge. Averaging lasts exactly AVG_LEN cycles and then the state becomes detection.
- R3: In detection only tiles 0 to DET_TILES-1 (default 2 of 16, mask 0x0003) are clock-enabled. A strobe on `det_valid` with `det_hit` low returns the state to averaging. With `det_hit` high it moves the state to synchronization.
- R4: In synchronization all tiles are clock-enabled, and the state holds until `sync_done`.
- R5: `sync_done` in synchronization captures `sync_phase` into `dll_phase`, which then holds until the next capture. It also loads `sync_shift` into `skip_cnt`, which then falls by one each cycle until it reaches zero.
- R6: In frame search only tiles 0 to SFD_TILES-1 (default mask 0x0001) are enabled. `sfd_found` and `sfd_timeout` are ignored while `skip_cnt` is non-zero. When both are high in the same cycle, the found result wins and the state becomes payload decoding.
- R7: A frame-search timeout with no found result goes to detection if `retry_on_timeout` is high, and to sleep otherwise.
- R8: Entering payload decoding loads `payload_len`. Each `bit_tick` counts one bit down, and the state returns to sleep on the tick of the last bit. A length of zero returns to sleep after one cycle. No tile is enabled during decoding.
- R9: `state_o` encodes sleep=0, averaging=1, decoding=2, detection=3, synchronization=4 and frame search=5. `rf_en` is high in every state except sleep.
- R10: `wake` has no effect outside sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | Start a reception from sleep |
| det_valid | input | 1 | Detection result strobe |
| det_hit | input | 1 | Detection outcome, qualified by det_valid |
| sync_done | input | 1 | Phase search finished |
| sync_phase | input | PHASE_W (4) | Winning phase index |
| sync_shift | input | SHIFT_W (5) | Winning sample offset |
| sfd_found | input | 1 | Start-of-frame pattern won |
| sfd_timeout | input | 1 | Frame search time limit reached |
| retry_on_timeout | input | 1 | Timeout goes to detection (1) or sleep (0) |
| payload_len | input | LEN_W (8) | Payload length in bits |
| bit_tick | input | 1 | One payload bit decoded |
| state_o | output | 3 | Current mode code |
| tile_clk_en | output | NUM_TILES (16) | Per-tile clock enables |
| rf_en | output | 1 | Front-end power enable |
| dll_phase | output | PHASE_W (4) | Phase code for the delay line |
| skip_cnt | output | SHIFT_W (5) | Samples still to skip |

## Verification
Two functions can fall in the same cycle in frame search: the found result and the timeout. Two further inputs compete with them: the skip countdown that masks both, and `wake`, which arrives while a packet is being decoded. The sweep raises found and timeout together in a third of the packets. It holds them high through the whole skip countdown, so every cycle of the countdown shows whether the state stayed in frame search. The edge after the count reaches zero must then show decoding and never detection or sleep. A separate pass raises the timeout alone with both retry settings, and `wake` is held high through decoding to show it changes nothing.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;
   typedef enum logic [2:0] {
      ST_SLEEP  = 3'd0,
      ST_AVG    = 3'd1,
      ST_DECODE = 3'd2,
      ST_DETECT = 3'd3,
      ST_SYNC   = 3'd4,
      ST_SFD    = 3'd5
   } rx_state_e;
endpackage

// File: rtl/rxseq_next.sv
module rxseq_next
   import rxseq_pkg::*;
(
   input  rx_state_e state,
   input  logic      wake,
   input  logic      avg_last,
   input  logic      det_valid,
   input  logic      det_hit,
   input  logic      sync_done,
   input  logic      skip_zero,
   input  logic      sfd_found,
   input  logic      sfd_timeout,
   input  logic      retry_on_timeout,
   input  logic      dec_zero,
   input  logic      dec_last,
   input  logic      bit_tick,
   output rx_state_e nxt
);
   always_comb begin
      nxt = state;
      unique case (state)
         ST_SLEEP:  if (wake) nxt = ST_AVG;
         ST_AVG:    if (avg_last) nxt = ST_DETECT;
         ST_DETECT: if (det_valid) nxt = det_hit ? ST_SYNC : ST_AVG;
         ST_SYNC:   if (sync_done) nxt = ST_SFD;
         ST_SFD: begin
            // alignment first; found outranks timeout
            if (skip_zero) begin
               if (sfd_found)        nxt = ST_DECODE;
               else if (sfd_timeout) nxt = retry_on_timeout ? ST_DETECT : ST_SLEEP;
            end
         end
         ST_DECODE: if (dec_zero || (dec_last && bit_tick)) nxt = ST_SLEEP;
         default:   nxt = ST_SLEEP;
      endcase
   end
endmodule

// File: rtl/rxseq_tilegate.sv
module rxseq_tilegate
   import rxseq_pkg::*;
#(
   parameter int NUM_TILES = 16,
   parameter int DET_TILES = 2,
   parameter int SFD_TILES = 1
) (
   input  rx_state_e            state,
   output logic [NUM_TILES-1:0] tile_en
);
   logic in_det, in_sync, in_sfd;
   assign in_det  = (state == ST_DETECT);
   assign in_sync = (state == ST_SYNC);
   assign in_sfd  = (state == ST_SFD);

   for (genvar i = 0; i < NUM_TILES; i++) begin : g_tile
      if (i < DET_TILES && i < SFD_TILES) begin : g_all
         assign tile_en[i] = in_det | in_sync | in_sfd;
      end else if (i < DET_TILES) begin : g_det
         assign tile_en[i] = in_det | in_sync;
      end else if (i < SFD_TILES) begin : g_sfd
         assign tile_en[i] = in_sync | in_sfd;
      end else begin : g_sync
         assign tile_en[i] = in_sync;
      end
   end
endmodule

// File: rtl/rxseq_ctrl.sv
module rxseq_ctrl
   import rxseq_pkg::*;
#(
   parameter int NUM_TILES  = 16,
   parameter int DET_TILES  = 2,
   parameter int SFD_TILES  = 1,
   parameter int NUM_SHIFTS = 32,
   parameter int AVG_LEN    = 4,
   parameter int LEN_W      = 8,
   parameter int PHASE_W    = $clog2(NUM_TILES),
   parameter int SHIFT_W    = $clog2(NUM_SHIFTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wake,
   input  logic                 det_valid,
   input  logic                 det_hit,
   input  logic                 sync_done,
   input  logic [PHASE_W-1:0]   sync_phase,
   input  logic [SHIFT_W-1:0]   sync_shift,
   input  logic                 sfd_found,
   input  logic                 sfd_timeout,
   input  logic                 retry_on_timeout,
   input  logic [LEN_W-1:0]     payload_len,
   input  logic                 bit_tick,
   output logic [2:0]           state_o,
   output logic [NUM_TILES-1:0] tile_clk_en,
   output logic                 rf_en,
   output logic [PHASE_W-1:0]   dll_phase,
   output logic [SHIFT_W-1:0]   skip_cnt
);
   localparam int AVG_W = $clog2(AVG_LEN + 1);

   if (NUM_TILES < 2 || (1 << PHASE_W) != NUM_TILES) begin : g_bad_tiles
      $error("rxseq_ctrl: NUM_TILES must be a power of two of at least 2");
   end
   if (DET_TILES < 1 || DET_TILES > NUM_TILES) begin : g_bad_det
      $error("rxseq_ctrl: DET_TILES out of range");
   end
   if (SFD_TILES < 1 || SFD_TILES > NUM_TILES) begin : g_bad_sfd
      $error("rxseq_ctrl: SFD_TILES out of range");
   end
   if (AVG_LEN < 1) begin : g_bad_avg
      $error("rxseq_ctrl: AVG_LEN must be at least 1");
   end
   if ((1 << SHIFT_W) != NUM_SHIFTS) begin : g_bad_shift
      $error("rxseq_ctrl: NUM_SHIFTS must be a power of two");
   end

   rx_state_e          state, nxt;
   logic [AVG_W-1:0]   avg_cnt;
   logic [LEN_W-1:0]   bits_left;
   logic [PHASE_W-1:0] phase_q;
   logic [SHIFT_W-1:0] skip_q;
   logic               sync_ld, avg_last, skip_zero, dec_zero, dec_last;

   assign sync_ld   = (state == ST_SYNC) && sync_done;
   assign avg_last  = (avg_cnt == AVG_W'(AVG_LEN - 1));
   assign skip_zero = (skip_q == '0);
   assign dec_zero  = (bits_left == '0);
   assign dec_last  = (bits_left == LEN_W'(1));

   rxseq_next u_next (
      .state            (state),
      .wake             (wake),
      .avg_last         (avg_last),
      .det_valid        (det_valid),
      .det_hit          (det_hit),
      .sync_done        (sync_done),
      .skip_zero        (skip_zero),
      .sfd_found        (sfd_found),
      .sfd_timeout      (sfd_timeout),
      .retry_on_timeout (retry_on_timeout),
      .dec_zero         (dec_zero),
      .dec_last         (dec_last),
      .bit_tick         (bit_tick),
      .nxt              (nxt)
   );

   rxseq_tilegate #(
      .NUM_TILES (NUM_TILES),
      .DET_TILES (DET_TILES),
      .SFD_TILES (SFD_TILES)
   ) u_gate (
      .state   (state),
      .tile_en (tile_clk_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_SLEEP;
         avg_cnt   <= '0;
         bits_left <= '0;
         phase_q   <= '0;
         skip_q    <= '0;
      end else begin
         state   <= nxt;
         avg_cnt <= (state == ST_AVG) ? avg_cnt + 1'b1 : '0;
         if (sync_ld) phase_q <= sync_phase;
         if (sync_ld)         skip_q <= sync_shift;
         else if (!skip_zero) skip_q <= skip_q - 1'b1;
         if (state == ST_SFD && nxt == ST_DECODE)
            bits_left <= payload_len;
         else if (state == ST_DECODE && bit_tick && !dec_zero)
            bits_left <= bits_left - 1'b1;
      end
   end

   assign state_o   = state;
   assign rf_en     = (state != ST_SLEEP);
   assign dll_phase = phase_q;
   assign skip_cnt  = skip_q;
endmodule

// File: rtl/rxseq_chk.sv
module rxseq_chk
   import rxseq_pkg::*;
#(
   parameter int NUM_TILES = 16,
   parameter int DET_TILES = 2,
   parameter int PHASE_W   = 4,
   parameter int SHIFT_W   = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wake,
   input logic                 sync_done,
   input logic [PHASE_W-1:0]   sync_phase,
   input logic                 sfd_found,
   input logic                 sfd_timeout,
   input logic                 retry_on_timeout,
   input logic [2:0]           state_o,
   input logic [NUM_TILES-1:0] tile_clk_en,
   input logic                 rf_en,
   input logic [PHASE_W-1:0]   dll_phase,
   input logic [SHIFT_W-1:0]   skip_cnt
);
   AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_SLEEP |-> (tile_clk_en == '0) && !rf_en); // R9
   AST_RF_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != ST_SLEEP |-> rf_en); // R9
   AST_DET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_DETECT |-> $countones(tile_clk_en) == DET_TILES); // R3
   AST_SYNC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_SYNC |-> &tile_clk_en); // R4
   AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_SYNC && sync_done |=> dll_phase == $past(sync_phase)); // R5
   AST_PHASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(state_o == ST_SYNC && sync_done) |=> $stable(dll_phase)); // R5
   AST_SKIP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      skip_cnt != '0 && !(state_o == ST_SYNC && sync_done)
      |=> skip_cnt == $past(skip_cnt) - 1'b1); // R5
   AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_SFD && skip_cnt != '0 |=> state_o == ST_SFD); // R6
   AST_FOUND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_SFD && skip_cnt == '0 && sfd_found |=> state_o == ST_DECODE); // R6
   AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_SFD && skip_cnt == '0 && !sfd_found && sfd_timeout
      |=> state_o == ($past(retry_on_timeout) ? ST_DETECT : ST_SLEEP)); // R7
   AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_DECODE && wake |=> state_o != ST_AVG); // R10
endmodule

bind rxseq_ctrl rxseq_chk #(
   .NUM_TILES (NUM_TILES),
   .DET_TILES (DET_TILES),
   .PHASE_W   (PHASE_W),
   .SHIFT_W   (SHIFT_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .wake             (wake),
   .sync_done        (sync_done),
   .sync_phase       (sync_phase),
   .sfd_found        (sfd_found),
   .sfd_timeout      (sfd_timeout),
   .retry_on_timeout (retry_on_timeout),
   .state_o          (state_o),
   .tile_clk_en      (tile_clk_en),
   .rf_en            (rf_en),
   .dll_phase        (dll_phase),
   .skip_cnt         (skip_cnt)
);

// File: tb/test_rxseq_ctrl.sv
module test_rxseq_ctrl;
   localparam int AVG_LEN = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wake = 0, det_valid = 0, det_hit = 0, sync_done = 0;
   logic [3:0]  sync_phase = 0;
   logic [4:0]  sync_shift = 0;
   logic        sfd_found = 0, sfd_timeout = 0, retry_on_timeout = 0, bit_tick = 0;
   logic [7:0]  payload_len = 0;
   logic [2:0]  state_o;
   logic [15:0] tile_clk_en;
   logic        rf_en;
   logic [3:0]  dll_phase;
   logic [4:0]  skip_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   rxseq_ctrl #(.AVG_LEN(AVG_LEN)) i_rxseq_ctrl (
      .clk(clk), .rst_n(rst_n), .wake(wake), .det_valid(det_valid), .det_hit(det_hit),
      .sync_done(sync_done), .sync_phase(sync_phase), .sync_shift(sync_shift),
      .sfd_found(sfd_found), .sfd_timeout(sfd_timeout), .retry_on_timeout(retry_on_timeout),
      .payload_len(payload_len), .bit_tick(bit_tick), .state_o(state_o),
      .tile_clk_en(tile_clk_en), .rf_en(rf_en), .dll_phase(dll_phase), .skip_cnt(skip_cnt)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // drive from sleep up to the start of frame search; checks R2..R5
   task automatic go_sfd(input int ph, input int sh, input bit miss);
      chk("R9 sleep code", int'(state_o), 0);
      wake = 1;
      step();
      wake = 0;
      chk("R2 enter averaging", int'(state_o), 1);
      chk("R9 rf on in averaging", int'(rf_en), 1);
      chk("R2 no tiles in averaging", int'(tile_clk_en), 0);
      repeat (AVG_LEN - 1) step();
      chk("R2 averaging length", int'(state_o), 1);
      step();
      chk("R2 detection after averaging", int'(state_o), 3);
      chk("R3 detection tile mask", int'(tile_clk_en), 16'h0003);
      if (miss) begin
         det_valid = 1; det_hit = 0;
         step();
         det_valid = 0;
         chk("R3 miss returns to averaging", int'(state_o), 1);
         repeat (AVG_LEN) step();
         chk("R2 detection again", int'(state_o), 3);
      end
      step();
      chk("R3 waits for result", int'(state_o), 3);
      det_valid = 1; det_hit = 1;
      step();
      det_valid = 0; det_hit = 0;
      chk("R3 hit enters sync", int'(state_o), 4);
      chk("R4 all tiles in sync", int'(tile_clk_en), 16'hFFFF);
      step(); step();
      chk("R4 sync waits", int'(state_o), 4);
      sync_done = 1; sync_phase = 4'(ph); sync_shift = 5'(sh);
      step();
      sync_done = 0; sync_phase = ~sync_phase; sync_shift = ~sync_shift;
      chk("R5 phase captured", int'(dll_phase), ph);
      chk("R5 skip loaded", int'(skip_cnt), sh);
      chk("R6 frame search state", int'(state_o), 5);
      chk("R6 frame search tile mask", int'(tile_clk_en), 16'h0001);
   endtask

   task automatic run_pkt(input int ph, input int sh, input int len, input bit miss, input bit both);
      go_sfd(ph, sh, miss);
      sfd_found = 1; sfd_timeout = both; retry_on_timeout = 1; payload_len = 8'(len);
      for (int k = 1; k <= sh; k++) begin
         step();
         chk("R6 found ignored during skip", int'(state_o), 5);
         chk("R5 skip countdown", int'(skip_cnt), sh - k);
      end
      step();
      sfd_found = 0; sfd_timeout = 0; payload_len = 8'hA5;
      chk("R6 found wins into decode", int'(state_o), 2);
      chk("R8 no tiles in decode", int'(tile_clk_en), 0);
      chk("R5 phase held", int'(dll_phase), ph);
      wake = 1;
      if (len == 0) begin
         step();
         chk("R8 zero length exits", int'(state_o), 0);
      end else begin
         step(); step();
         chk("R10 wake ignored in decode", int'(state_o), 2);
         bit_tick = 1;
         for (int k = 1; k < len; k++) begin
            step();
            chk("R8 decoding bits", int'(state_o), 2);
         end
         step();
         chk("R8 last bit exits", int'(state_o), 0);
      end
      wake = 0; bit_tick = 0;
      chk("R9 rf off in sleep", int'(rf_en), 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #35;
      chk("R1 reset state", int'(state_o), 0);
      chk("R1 reset tiles", int'(tile_clk_en), 0);
      chk("R1 reset rf", int'(rf_en), 0);
      chk("R1 reset phase", int'(dll_phase), 0);
      chk("R1 reset skip", int'(skip_cnt), 0);
      rst_n = 1;
      step();
      chk("R1 sleep holds", int'(state_o), 0);

      for (int p = 0; p < 16; p++)
         run_pkt(p, (p * 13 + 5) % 32, (p * 3) % 17, p[0], (p % 3) == 0);
      run_pkt(7, 0, 1, 1'b0, 1'b1);
      run_pkt(12, 31, 0, 1'b1, 1'b1);

      // timeout with retry: back to detection
      go_sfd(3, 2, 1'b0);
      sfd_timeout = 1; retry_on_timeout = 1;
      step(); step();
      chk("R6 timeout ignored during skip", int'(state_o), 5);
      step();
      chk("R7 timeout retries detection", int'(state_o), 3);
      chk("R7 detection mask after retry", int'(tile_clk_en), 16'h0003);
      sfd_timeout = 0;
      det_valid = 1; det_hit = 1;
      step();
      det_valid = 0; det_hit = 0;
      chk("R3 hit after retry", int'(state_o), 4);
      sync_done = 1; sync_phase = 4'd9; sync_shift = 5'd0;
      step();
      sync_done = 0;
      chk("R5 second capture", int'(dll_phase), 9);
      sfd_timeout = 1; retry_on_timeout = 0;
      step();
      sfd_timeout = 0;
      chk("R7 timeout to sleep", int'(state_o), 0);
      chk("R9 rf off after timeout", int'(rf_en), 0);
      step();
      chk("R5 phase kept in sleep", int'(dll_phase), 9);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule